// File: doc/BRIEF.md
# Event Sequence Numbering and Readout Handshake Controller

This block is the master sequencer that stamps every accepted level-1 trigger with a 12-bit running event number and a 4-bit type code. It broadcasts the packed 16-bit word on a parallel port together with a one-cycle data strobe. It then holds its generator-busy level high until every participating readout controller has acknowledged the event. A controller acknowledges by raising its own busy line and later dropping it again once it has stored its data. New triggers are accepted only when generator-busy is low.

On request, the block issues a burst of synchronization events. Each event in the burst carries the all-ones type code and runs the complete broadcast and handshake. The burst length comes from a configuration input, normally 4, and is chosen so that downstream pipelines are pushed empty. Controllers can be excluded from the handshake with a mask. A programmable timeout recovers from a controller that never answers. Triggers that arrive while the block is busy are counted.

Top module: `evgen_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it is released, gen_busy, evt_strobe, timeout_err, rej_count and evt_word all read zero.
- R2: A trigger sampled in idle raises gen_busy one clock later. The event number in evt_word[11:0] changes one clock after that, and evt_strobe rises one clock after the number has changed.
- R3: evt_strobe is high for exactly one clock cycle, and evt_word is unchanged in the cycle before, during and after the strobe.
- R4: evt_word[11:0] grows by exactly one per issued event, including each sync event, and wraps from 4095 to 0.
- R5: For a level-1 trigger, evt_word[15:12] equals spec_bits as sampled with the trigger: 0000 for a normal trigger, or a one-hot code (1000, 0100, 0010, 0001) for a special one.
- R6: A sync_req sampled in idle with a nonzero sync_count issues sync_count events back to back. Each has type 1111, and gen_busy stays high from the first event to the end of the last. A sync_req wins over a level-1 trigger in the same cycle. A sync_req with sync_count of 0 does nothing.
- R7: gen_busy falls only after every unmasked readout controller has raised its busy line after the strobe and then lowered it again. It falls two clocks after the last such release.
- R8: A readout controller whose rdo_mask bit is 1 when the strobe is issued takes no part in that handshake, and its busy line has no effect. With every controller masked, gen_busy falls two clocks after the strobe.
- R9: Every cycle in which l1_trig is high but is not accepted (gen_busy high, or a sync request taken in the same cycle) adds one to rej_count. The counter saturates at its maximum, and rejected triggers issue no event.
- R10: With a nonzero timeout_cycles, a handshake still incomplete after that many cycles in the handshake phase sets timeout_err, which stays set until reset. It also drops gen_busy and abandons the rest of any sync burst. A timeout_cycles of 0 disables the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l1_trig | input | 1 | Level-1 trigger, sampled each cycle |
| spec_bits | input | 4 | Special-event pattern copied into the type field |
| sync_req | input | 1 | Request for a sync burst |
| sync_count | input | SYNC_W | Number of sync events per burst |
| rdo_busy | input | NUM_RDO | Busy line of each readout controller |
| rdo_mask | input | NUM_RDO | 1 excludes that controller from the handshake |
| timeout_cycles | input | TMO_W | Handshake timeout in cycles, 0 disables |
| evt_word | output | 16 | Type in bits 15:12, event number in bits 11:0 |
| evt_strobe | output | 1 | One-cycle data-valid strobe |
| gen_busy | output | 1 | Generator-busy level |
| timeout_err | output | 1 | Sticky handshake timeout flag |
| rej_count | output | REJ_W | Saturating count of rejected trigger cycles |

## Verification
The bench builds the block with three readout controllers, a 3-bit rejected-trigger counter, an 8-bit timeout field and a 4-bit burst length. The narrow counter lets a single trigger held high for a few cycles drive the count into saturation. Three controllers are enough for partial masks, a controller that never answers, and the case where all are masked. The event number width is fixed by the word format, so the wrap test issues 4096 fully masked events, each of which completes in a handful of cycles.

// File: rtl/evgen_pkg.sv
package evgen_pkg;

    localparam int EVT_NUM_W  = 12;
    localparam int EVT_TYPE_W = 4;
    localparam int EVT_WORD_W = EVT_NUM_W + EVT_TYPE_W;

    localparam logic [EVT_TYPE_W-1:0] TYPE_SYNC = '1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUMP,
        ST_SEND,
        ST_HAND
    } seq_state_e;

    typedef enum logic [1:0] {
        TRK_IDLE,
        TRK_WAIT_HI,
        TRK_WAIT_LO,
        TRK_DONE
    } trk_phase_e;

endpackage

// File: rtl/evgen_trk.sv
module evgen_trk
    import evgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic masked,
    input  logic busy_in,
    output logic done
);

    typedef struct packed {
        trk_phase_e phase;
    } trk_regs_t;

    trk_regs_t q, d;

    always_comb begin
        d = q;
        if (arm) begin
            d.phase = masked ? TRK_DONE : TRK_WAIT_HI;
        end else begin
            unique case (q.phase)
                TRK_WAIT_HI: if (busy_in)  d.phase = TRK_WAIT_LO;
                TRK_WAIT_LO: if (!busy_in) d.phase = TRK_DONE;
                default:     d.phase = q.phase;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '{phase: TRK_IDLE};
        else     q <= d;
    end

    assign done = (q.phase == TRK_DONE);

    // R8: a masked controller is complete right after arming
    a_r8_masked_done: assert property (@(posedge clk) disable iff (rst)
        (arm && masked) |=> done);

    // R7: completion is kept until the next arming
    a_r7_done_held: assert property (@(posedge clk) disable iff (rst)
        (done && !arm) |=> done);

endmodule

// File: rtl/evgen_rejcnt.sv
module evgen_rejcnt #(
    parameter int REJ_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    output logic [REJ_W-1:0] count
);

    localparam logic [REJ_W-1:0] CNT_MAX = '1;

    logic [REJ_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (hit && (cnt_q != CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    a_r9_saturated: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_MAX) |=> (count == CNT_MAX));

    a_r9_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(count));

endmodule

// File: rtl/evgen_seq.sv
module evgen_seq
    import evgen_pkg::*;
#(
    parameter int TMO_W  = 16,
    parameter int SYNC_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  l1_trig,
    input  logic [EVT_TYPE_W-1:0] spec_bits,
    input  logic                  sync_req,
    input  logic [SYNC_W-1:0]     sync_count,
    input  logic [TMO_W-1:0]      timeout_cycles,
    input  logic                  all_done,
    output logic [EVT_WORD_W-1:0] evt_word,
    output logic                  evt_strobe,
    output logic                  gen_busy,
    output logic                  timeout_err,
    output logic                  arm,
    output logic                  reject
);

    typedef struct packed {
        seq_state_e            state;
        logic [EVT_NUM_W-1:0]  num;
        logic [EVT_TYPE_W-1:0] typ;
        logic [SYNC_W-1:0]     left;
        logic                  busy;
        logic                  strobe;
        logic [TMO_W-1:0]      tmo;
        logic                  err;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{
        state:  ST_IDLE,
        num:    '0,
        typ:    '0,
        left:   '0,
        busy:   1'b0,
        strobe: 1'b0,
        tmo:    '0,
        err:    1'b0
    };

    seq_regs_t q, d;
    logic      sync_go;
    logic      tmo_on;
    logic      tmo_hit;

    assign sync_go = sync_req && (sync_count != '0);
    assign tmo_on  = (timeout_cycles != '0);
    assign tmo_hit = tmo_on && (q.tmo == timeout_cycles - 1'b1);

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        reject   = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (sync_go) begin
                    d.busy  = 1'b1;
                    d.typ   = TYPE_SYNC;
                    d.left  = sync_count - 1'b1;
                    d.state = ST_BUMP;
                    reject  = l1_trig;
                end else if (l1_trig) begin
                    d.busy  = 1'b1;
                    d.typ   = spec_bits;
                    d.left  = '0;
                    d.state = ST_BUMP;
                end
            end
            ST_BUMP: begin
                reject  = l1_trig;
                d.num   = q.num + 1'b1;
                d.state = ST_SEND;
            end
            ST_SEND: begin
                reject   = l1_trig;
                d.strobe = 1'b1;
                d.tmo    = '0;
                d.state  = ST_HAND;
            end
            ST_HAND: begin
                reject = l1_trig;
                if (all_done && !q.strobe) begin
                    if (q.left != '0) begin
                        d.left  = q.left - 1'b1;
                        d.state = ST_BUMP;
                    end else begin
                        d.busy  = 1'b0;
                        d.state = ST_IDLE;
                    end
                end else if (tmo_hit) begin
                    d.err   = 1'b1;
                    d.busy  = 1'b0;
                    d.left  = '0;
                    d.state = ST_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            default: d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= SEQ_RST;
        else     q <= d;
    end

    assign evt_word    = {q.typ, q.num};
    assign evt_strobe  = q.strobe;
    assign gen_busy    = q.busy;
    assign timeout_err = q.err;
    assign arm         = q.strobe;

    a_r2_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
        evt_strobe |-> gen_busy);

    a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
        evt_strobe |=> !evt_strobe);

    a_r3_word_before: assert property (@(posedge clk) disable iff (rst)
        evt_strobe |-> $stable(evt_word));

    a_r3_word_after: assert property (@(posedge clk) disable iff (rst)
        evt_strobe |=> $stable(evt_word));

    // R7: busy is released only after the trackers report completion, or on timeout
    a_r7_release_gate: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_busy) |-> ($past(all_done) || timeout_err));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        timeout_err |=> timeout_err);

endmodule

// File: rtl/evgen_ctrl.sv
module evgen_ctrl
    import evgen_pkg::*;
#(
    parameter int NUM_RDO = 3,
    parameter int TMO_W   = 16,
    parameter int REJ_W   = 16,
    parameter int SYNC_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  l1_trig,
    input  logic [EVT_TYPE_W-1:0] spec_bits,
    input  logic                  sync_req,
    input  logic [SYNC_W-1:0]     sync_count,
    input  logic [NUM_RDO-1:0]    rdo_busy,
    input  logic [NUM_RDO-1:0]    rdo_mask,
    input  logic [TMO_W-1:0]      timeout_cycles,
    output logic [EVT_WORD_W-1:0] evt_word,
    output logic                  evt_strobe,
    output logic                  gen_busy,
    output logic                  timeout_err,
    output logic [REJ_W-1:0]      rej_count
);

    logic [NUM_RDO-1:0] trk_done;
    logic               all_done;
    logic               arm;
    logic               reject;

    assign all_done = &trk_done;

    evgen_seq #(
        .TMO_W  (TMO_W),
        .SYNC_W (SYNC_W)
    ) i_seq (
        .clk            (clk),
        .rst            (rst),
        .l1_trig        (l1_trig),
        .spec_bits      (spec_bits),
        .sync_req       (sync_req),
        .sync_count     (sync_count),
        .timeout_cycles (timeout_cycles),
        .all_done       (all_done),
        .evt_word       (evt_word),
        .evt_strobe     (evt_strobe),
        .gen_busy       (gen_busy),
        .timeout_err    (timeout_err),
        .arm            (arm),
        .reject         (reject)
    );

    for (genvar g = 0; g < NUM_RDO; g++) begin : g_trk
        evgen_trk i_trk (
            .clk     (clk),
            .rst     (rst),
            .arm     (arm),
            .masked  (rdo_mask[g]),
            .busy_in (rdo_busy[g]),
            .done    (trk_done[g])
        );
    end

    evgen_rejcnt #(
        .REJ_W (REJ_W)
    ) i_rejcnt (
        .clk   (clk),
        .rst   (rst),
        .hit   (reject),
        .count (rej_count)
    );

    // R9: a rejected trigger never issues an event in the following cycle
    a_r9_reject_no_start: assert property (@(posedge clk) disable iff (rst)
        (l1_trig && gen_busy) |=> $stable(evt_word[EVT_NUM_W-1:0]) || evt_strobe || gen_busy);

endmodule

// File: tb/test_evgen_ctrl.sv
module test_evgen_ctrl;

    localparam int N  = 3;
    localparam int TW = 8;
    localparam int RW = 3;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          l1_trig = 1'b0;
    logic [3:0]    spec_bits = '0;
    logic          sync_req = 1'b0;
    logic [SW-1:0] sync_count = 4'd4;
    logic [N-1:0]  rdo_busy = '0;
    logic [N-1:0]  rdo_mask = '0;
    logic [TW-1:0] timeout_cycles = '0;
    logic [15:0]   evt_word;
    logic          evt_strobe;
    logic          gen_busy;
    logic          timeout_err;
    logic [RW-1:0] rej_count;

    int checks = 0;
    int fails  = 0;
    int exp_num = 0;

    // spec bits in [6:3], mask in [2:0]
    localparam logic [6:0] VEC [6] = '{
        {4'h0, 3'b000}, {4'h8, 3'b001}, {4'h4, 3'b010},
        {4'h2, 3'b100}, {4'h1, 3'b011}, {4'h0, 3'b111}
    };

    always #5 clk = ~clk;

    evgen_ctrl #(.NUM_RDO(N), .TMO_W(TW), .REJ_W(RW), .SYNC_W(SW)) i_evgen_ctrl (
        .clk(clk), .rst(rst), .l1_trig(l1_trig), .spec_bits(spec_bits),
        .sync_req(sync_req), .sync_count(sync_count), .rdo_busy(rdo_busy),
        .rdo_mask(rdo_mask), .timeout_cycles(timeout_cycles), .evt_word(evt_word),
        .evt_strobe(evt_strobe), .gen_busy(gen_busy), .timeout_err(timeout_err),
        .rej_count(rej_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_num = 0;
    endtask

    // Drives one trigger and checks the issue timeline (R2, R3, R4, R5).
    task automatic send_trigger(input logic [3:0] sp);
        @(negedge clk) l1_trig = 1'b1; spec_bits = sp;
        @(negedge clk) l1_trig = 1'b0;
        check("R2 busy first", gen_busy, 1);
        check("R2 number not yet bumped", evt_word[11:0], exp_num);
        exp_num = (exp_num + 1) % 4096;
        @(negedge clk);
        check("R4 number step", evt_word[11:0], exp_num);
        check("R5 type field", evt_word[15:12], sp);
        check("R2 no strobe yet", evt_strobe, 0);
        @(negedge clk);
        check("R3 strobe high", evt_strobe, 1);
        check("R3 word during strobe", evt_word, {sp, exp_num[11:0]});
        @(negedge clk);
        check("R3 strobe one cycle", evt_strobe, 0);
        check("R3 word after strobe", evt_word, {sp, exp_num[11:0]});
    endtask

    // Runs the busy handshake for the current mask; masked lines are held high (R7, R8).
    task automatic respond(input logic [N-1:0] m);
        if (m == '1) begin
            @(negedge clk);
            check("R8 all masked release", gen_busy, 0);
        end else begin
            rdo_busy = '1;
            repeat (2) @(negedge clk);
            check("R7 busy while controllers busy", gen_busy, 1);
            rdo_busy = m;
            @(negedge clk);
            check("R7 busy one cycle after release", gen_busy, 1);
            @(negedge clk);
            check("R7 released", gen_busy, 0);
            rdo_busy = '0;
        end
    endtask

    task automatic quick_event();
        @(negedge clk) l1_trig = 1'b1; spec_bits = 4'h0;
        @(negedge clk) l1_trig = 1'b0;
        for (int k = 0; k < 20 && gen_busy; k++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1 reset state
        @(negedge clk);
        check("R1 busy in reset", gen_busy, 0);
        check("R1 word in reset", evt_word, 0);
        do_reset();
        @(negedge clk);
        check("R1 busy after reset", gen_busy, 0);
        check("R1 strobe after reset", evt_strobe, 0);
        check("R1 word after reset", evt_word, 0);
        check("R1 err after reset", timeout_err, 0);
        check("R1 rej after reset", rej_count, 0);

        // Table-driven triggers: type codes and masks (R5, R8)
        for (int v = 0; v < 6; v++) begin
            rdo_mask = VEC[v][2:0];
            send_trigger(VEC[v][6:3]);
            respond(VEC[v][2:0]);
        end

        // R9: held trigger during busy is counted and saturates; timeout 0 never fires (R10)
        rdo_mask = '0;
        send_trigger(4'h0);
        @(negedge clk) l1_trig = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 rejected count", rej_count, 3);
        repeat (6) @(negedge clk);
        check("R9 saturates", rej_count, 7);
        l1_trig = 1'b0;
        repeat (40) @(negedge clk);
        check("R10 disabled timeout keeps busy", gen_busy, 1);
        check("R10 disabled timeout no err", timeout_err, 0);
        respond('0);
        send_trigger(4'h2);
        respond('0);

        // R7: partial response does not release
        send_trigger(4'h0);
        rdo_busy = 3'b011;
        repeat (2) @(negedge clk);
        rdo_busy = 3'b000;
        repeat (5) @(negedge clk);
        check("R7 waits for silent controller", gen_busy, 1);
        rdo_busy = 3'b100;
        @(negedge clk) rdo_busy = 3'b000;
        repeat (2) @(negedge clk);
        check("R7 last controller completes", gen_busy, 0);

        // R6: sync burst beats a simultaneous trigger
        do_reset();
        rdo_mask = '1;
        @(negedge clk) sync_req = 1'b1; l1_trig = 1'b1; spec_bits = 4'h8;
        @(negedge clk) sync_req = 1'b0; l1_trig = 1'b0;
        begin
            int n_sync = 0;
            bit early = 0;
            for (int k = 0; k < 60 && gen_busy; k++) begin
                if (evt_strobe) begin
                    exp_num++;
                    n_sync++;
                    check("R6 sync word", evt_word, {4'hF, exp_num[11:0]});
                end
                @(negedge clk);
                if (!gen_busy && n_sync < 4) early = 1;
            end
            check("R6 sync event count", n_sync, 4);
            check("R6 busy held through burst", early, 0);
            check("R9 trigger lost to sync counted", rej_count, 1);
        end

        // R6: zero burst length ignored
        sync_count = '0;
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 zero count ignored", gen_busy, 0);
        check("R6 zero count no number change", evt_word[11:0], exp_num);
        sync_count = 4'd4;

        // R4: wrap from 4095 to 0
        do_reset();
        rdo_mask = '1;
        for (int i = 0; i < 4095; i++) quick_event();
        exp_num = 4095;
        check("R4 reached 4095", evt_word[11:0], 4095);
        send_trigger(4'h0);
        check("R4 wrapped to 0", evt_word[11:0], 0);
        respond('1);

        // R10: timeout with a silent controller
        rdo_mask = '0;
        timeout_cycles = 8'd10;
        send_trigger(4'h1);
        repeat (5) @(negedge clk);
        check("R10 busy before timeout", gen_busy, 1);
        check("R10 no err before timeout", timeout_err, 0);
        for (int k = 0; k < 30 && gen_busy; k++) @(negedge clk);
        check("R10 busy dropped on timeout", gen_busy, 0);
        check("R10 err set", timeout_err, 1);
        repeat (3) @(negedge clk);
        check("R10 err sticky", timeout_err, 1);

        finish_run();
    end

endmodule